// File: doc/BRIEF.md
# Addressable Asynchronous Serial Receiver

This block receives characters on one asynchronous serial line and hands them to the rest of the chip through a small input buffer. An external baud generator supplies a one-cycle sample tick at sixteen times the bit rate. Each character is a low start bit, then eight data bits sent least significant bit first, then an optional ninth bit, then a high stop bit. The receiver checks the start bit at mid-bit and samples every later bit at the centre of its bit time.

Finished characters go into a two-entry first-in first-out buffer. Each entry holds the data byte, the ninth bit and a framing flag. A read strobe removes the oldest entry, and the outputs always show the entry at the head of the buffer. If a character arrives while the buffer is full, a sticky overrun condition is set and reception stops until the receive enable is dropped.

In nine-bit mode an address filter can be switched on. While it is on, the receiver discards every character whose ninth bit is clear. This lets a node on a shared line ignore data that is meant for other nodes until it sees an address character.

Top module: `rxa_receiver`

## Requirements
- R1: After reset, rx_avail and overrun are both 0.
- R2: In 8-bit mode (nine_bit_mode=0), a frame of a low start bit, 8 data bits sent least significant bit first and a high stop bit puts the byte on rx_data, with rx_bit8=0 and rx_frame_err=0.
- R3: In 9-bit mode (nine_bit_mode=1), the bit that follows data bit 7 is stored with its character and appears on rx_bit8.
- R4: A character whose stop bit is sampled low is stored with rx_frame_err=1. The flag belongs to each buffer entry and shows the status of the character at the head of the buffer.
- R5: rx_avail is 1 exactly when the buffer holds at least one character. A read_strobe pulse removes the head entry. A read_strobe pulse while the buffer is empty changes nothing.
- R6: The buffer holds two complete characters and returns them in the order they arrived.
- R7: A character that completes while both entries are full, with no read in the same cycle, sets overrun and is discarded. The two stored entries are kept unchanged.
- R8: While overrun is 1, no further character is stored, and overrun stays 1 as long as rx_enable stays 1.
- R9: While rx_enable is 0, nothing is received and overrun clears. Characters already buffered stay readable. Reception resumes once rx_enable returns to 1.
- R10: When addr_detect_en=1 in 9-bit mode, a character with ninth bit 0 is discarded and a character with ninth bit 1 is stored. In 8-bit mode addr_detect_en has no effect.
- R11: A low pulse on rx_serial that is shorter than half a bit time is not taken as a start bit, and no character results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_serial | input | 1 | Asynchronous serial input, idles high |
| rx_enable | input | 1 | Receive enable; driving it low clears overrun |
| nine_bit_mode | input | 1 | 1 selects 9-bit characters |
| addr_detect_en | input | 1 | Enables the address filter in 9-bit mode |
| read_strobe | input | 1 | Removes the head character from the buffer |
| rx_data | output | 8 | Data byte of the head entry |
| rx_bit8 | output | 1 | Ninth bit of the head entry |
| rx_frame_err | output | 1 | Framing flag of the head entry |
| rx_avail | output | 1 | Buffer holds at least one character |
| overrun | output | 1 | Sticky overrun condition |

## Verification
The assertions check on every cycle how the flags and the buffer relate over time. rx_avail can only rise after a character completes, and it can only fall after a read. overrun can only rise while the buffer is occupied, it holds while rx_enable is high, it clears while rx_enable is low, and nothing is stored while it is set. A filtered address-mode character must never fill an empty buffer. Only the bench scenarios can show that data bits are put together in the right order, that the ninth bit and the framing flag stay with their own character through the buffer, that glitches are rejected, and that the two buffered characters survive an overrun.

// File: rtl/rxa_pkg.sv
// Shared definitions for the addressable serial receiver.
// Assumes a fixed data byte width; the ninth bit is carried separately.
package rxa_pkg;
    parameter int RXA_DATA_W = 8;

    // One buffered character with its ninth bit and framing status.
    typedef struct packed {
        logic [RXA_DATA_W-1:0] data;
        logic                  bit8;
        logic                  ferr;
    } rxa_entry_t;

    // Receive state machine states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rxa_state_t;
endpackage

// File: rtl/rxa_sync.sv
// Two-flop synchronizer for the asynchronous serial input.
// Assumes the line idles high, so both flops reset to 1.
module rxa_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;

    // Moves the input through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            dout   <= 1'b1;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/rxa_deserializer.sv
// Bit-level receive engine. It finds a falling edge on sample ticks,
// confirms the start bit at mid-bit, samples each later bit at its
// centre, and pulses char_done with the assembled character when the
// stop bit is sampled. Assumes tick comes at OVERSAMPLE times the bit rate.
module rxa_deserializer
    import rxa_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic       run,
    input  logic       nine_bit,
    output logic       char_done,
    output rxa_entry_t char_out
);
    localparam int CNT_W    = $clog2(OVERSAMPLE);
    localparam int BIT_W    = $clog2(RXA_DATA_W + 2);
    localparam int SHR_W    = RXA_DATA_W + 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);

    rxa_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bidx;
    logic [BIT_W-1:0]  last_idx;
    logic [SHR_W-1:0]  shreg;
    logic              prev_s;

    // Index of the final data bit for the selected character length.
    always_comb begin
        last_idx = nine_bit ? BIT_W'(RXA_DATA_W) : BIT_W'(RXA_DATA_W - 1);
    end

    // Steps the frame state machine on each sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= '0;
            prev_s    <= 1'b1;
            char_done <= 1'b0;
            char_out  <= '0;
        end else begin
            char_done <= 1'b0;
            if (!run) begin
                state  <= ST_IDLE;
                prev_s <= rx_s;
            end else if (tick) begin
                case (state)
                    ST_IDLE: begin
                        prev_s <= rx_s;
                        if (prev_s && !rx_s) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID_CNT) begin
                            cnt  <= '0;
                            bidx <= '0;
                            state <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST_CNT) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[SHR_W-1:1]};
                            if (bidx == last_idx) state <= ST_STOP;
                            else                  bidx  <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt == LAST_CNT) begin
                            cnt       <= '0;
                            state     <= ST_IDLE;
                            prev_s    <= rx_s;
                            char_done <= 1'b1;
                            char_out.ferr <= !rx_s;
                            if (nine_bit) begin
                                char_out.data <= shreg[RXA_DATA_W-1:0];
                                char_out.bit8 <= shreg[SHR_W-1];
                            end else begin
                                char_out.data <= shreg[SHR_W-1:1];
                                char_out.bit8 <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rxa_buffer.sv
// Small first-in first-out store for received characters. The head
// entry is always visible. A pop on an empty store is ignored. A push
// is taken only when can_accept is high, which includes a full store
// that is popped in the same cycle.
module rxa_buffer
    import rxa_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  rxa_entry_t push_entry,
    input  logic       pop,
    output logic       can_accept,
    output logic       not_empty,
    output rxa_entry_t head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    rxa_entry_t        slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_pop, do_push;

    // Works out which operations take effect this cycle.
    always_comb begin
        not_empty  = (count != '0);
        do_pop     = pop && not_empty;
        can_accept = (count != CNT_FULL) || do_pop;
        do_push    = push && can_accept;
        head       = slots[rd_ptr];
    end

    // Writes the slots; each slot is a plain register.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                              slots[g] <= '0;
            else if (do_push && wr_ptr == PTR_W'(g)) slots[g] <= push_entry;
        end
    end

    // Moves the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/rxa_receiver.sv
// Top of the addressable asynchronous receiver. It connects the
// synchronizer, the bit engine and the two-entry buffer, applies the
// address filter and keeps the sticky overrun flag. Assumes sample_tick
// comes from an external generator at OVERSAMPLE times the bit rate.
module rxa_receiver
    import rxa_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int BUF_DEPTH  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_tick,
    input  logic                  rx_serial,
    input  logic                  rx_enable,
    input  logic                  nine_bit_mode,
    input  logic                  addr_detect_en,
    input  logic                  read_strobe,
    output logic [RXA_DATA_W-1:0] rx_data,
    output logic                  rx_bit8,
    output logic                  rx_frame_err,
    output logic                  rx_avail,
    output logic                  overrun
);
    logic       rx_s;
    logic       char_done;
    rxa_entry_t char_q;
    rxa_entry_t head;
    logic       keep_char;
    logic       store_req;
    logic       can_accept;
    logic       ovr_q;

    rxa_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_serial),
        .dout  (rx_s)
    );

    rxa_deserializer #(.OVERSAMPLE(OVERSAMPLE)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_tick),
        .rx_s      (rx_s),
        .run       (rx_enable && !ovr_q),
        .nine_bit  (nine_bit_mode),
        .char_done (char_done),
        .char_out  (char_q)
    );

    // Address filter: drop non-address characters in 9-bit address mode.
    always_comb begin
        keep_char = !(nine_bit_mode && addr_detect_en && !char_q.bit8);
        store_req = char_done && keep_char;
    end

    rxa_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (store_req),
        .push_entry (char_q),
        .pop        (read_strobe),
        .can_accept (can_accept),
        .not_empty  (rx_avail),
        .head       (head)
    );

    // Sticky overrun: set on a refused store, cleared by dropping enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ovr_q <= 1'b0;
        else if (!rx_enable)              ovr_q <= 1'b0;
        else if (store_req && !can_accept) ovr_q <= 1'b1;
    end

    // Presents the head entry and the flag on the ports.
    always_comb begin
        rx_data      = head.data;
        rx_bit8      = head.bit8;
        rx_frame_err = head.ferr;
        overrun      = ovr_q;
    end
endmodule

// File: rtl/rxa_receiver_checker.sv
// Cycle-by-cycle properties of the receiver, bound into the top module.
module rxa_receiver_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_enable,
    input logic read_strobe,
    input logic rx_avail,
    input logic overrun,
    input logic char_done,
    input logic nine_bit_mode,
    input logic addr_detect_en,
    input logic char_bit8
);
    assert_avail_needs_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_avail) |-> $past(char_done));

    assert_avail_falls_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_avail) |-> $past(read_strobe));

    assert_overrun_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_avail));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_enable) |=> overrun);

    assert_no_store_in_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_avail) |-> !$past(overrun));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !overrun);

    assert_addr_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && nine_bit_mode && addr_detect_en && !char_bit8 && !rx_avail)
        |=> !rx_avail);
endmodule

bind rxa_receiver rxa_receiver_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_enable      (rx_enable),
    .read_strobe    (read_strobe),
    .rx_avail       (rx_avail),
    .overrun        (overrun),
    .char_done      (char_done),
    .nine_bit_mode  (nine_bit_mode),
    .addr_detect_en (addr_detect_en),
    .char_bit8      (char_q.bit8)
);

// File: tb/rxa_receiver_test.sv
// Self-checking bench: directed corner cases plus seeded random frames.
module rxa_receiver_test;
    localparam int TICK_DIV = 3;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rx_serial = 1'b1;
    logic       rx_enable = 1'b0;
    logic       nine_bit_mode = 1'b0;
    logic       addr_detect_en = 1'b0;
    logic       read_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, rx_frame_err, rx_avail, overrun;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    int tick_cnt = 0;

    rxa_receiver uut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .rx_serial(rx_serial), .rx_enable(rx_enable),
        .nine_bit_mode(nine_bit_mode), .addr_detect_en(addr_detect_en),
        .read_strobe(read_strobe), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .rx_frame_err(rx_frame_err), .rx_avail(rx_avail), .overrun(overrun)
    );

    always #10 clk = ~clk;

    // Sample tick: one cycle in every TICK_DIV, changed away from the edge.
    always @(negedge clk) begin
        tick_cnt    <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        sample_tick <= (tick_cnt == 0);
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic line_bit(input logic v);
        @(negedge clk) rx_serial = v;
        repeat (BIT_CLKS - 1) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic b8, input logic stop_v);
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        if (nine_bit_mode) line_bit(b8);
        line_bit(stop_v);
        line_bit(1'b1);
    endtask

    task automatic pop();
        @(negedge clk) read_strobe = 1'b1;
        @(negedge clk) read_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_head(input string req, input int d, input int b8, input int fe);
        chk({req, " avail"}, rx_avail, 1);
        chk({req, " data"}, rx_data, d);
        chk({req, " bit8"}, rx_bit8, b8);
        chk({req, " ferr"}, rx_frame_err, fe);
    endtask

    // Bench model of the address filter and of the stored ninth bit.
    function automatic bit exp_keep(input bit nine, input bit adr, input bit b8);
        return !(nine && adr && !b8);
    endfunction
    function automatic int exp_bit8(input bit nine, input bit b8);
        return nine ? int'(b8) : 0;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 avail", rx_avail, 0);
        chk("R1 overrun", overrun, 0);
        // R5 read on empty buffer has no effect
        pop();
        chk("R5 empty read avail", rx_avail, 0);
        chk("R5 empty read overrun", overrun, 0);

        rx_enable = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);

        // R2 basic 8-bit frame
        send(8'hA5, 1'b0, 1'b1);
        chk_head("R2", 8'hA5, 0, 0);
        pop();
        chk("R5 avail after pop", rx_avail, 0);

        // R3 nine-bit character
        nine_bit_mode = 1'b1;
        send(8'h3C, 1'b1, 1'b1);
        chk_head("R3", 8'h3C, 1, 0);
        pop();

        // R4 framing flag per entry, R6 ordering
        nine_bit_mode = 1'b0;
        send(8'h81, 1'b0, 1'b0);
        send(8'h7E, 1'b0, 1'b1);
        chk_head("R4 bad stop", 8'h81, 0, 1);
        pop();
        chk_head("R4 R6 second", 8'h7E, 0, 0);
        pop();
        chk("R6 empty", rx_avail, 0);

        // R7 overrun with two held, R8 blocking
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1);
        chk("R7 no overrun yet", overrun, 0);
        send(8'h33, 1'b0, 1'b1);
        chk("R7 overrun set", overrun, 1);
        chk_head("R7 head kept", 8'h11, 0, 0);
        send(8'h44, 1'b0, 1'b1);
        chk("R8 overrun held", overrun, 1);
        pop();
        chk_head("R7 second kept", 8'h22, 0, 0);
        pop();
        chk("R8 nothing stored while blocked", rx_avail, 0);
        chk("R8 still set", overrun, 1);

        // R9 enable low clears overrun, blocks reception, keeps entries
        @(negedge clk) rx_enable = 1'b0;
        @(negedge clk);
        chk("R9 overrun cleared", overrun, 0);
        send(8'h55, 1'b0, 1'b1);
        chk("R9 disabled no rx", rx_avail, 0);
        rx_enable = 1'b1;
        send(8'h66, 1'b0, 1'b1);
        @(negedge clk) rx_enable = 1'b0;
        @(negedge clk) rx_enable = 1'b1;
        chk_head("R9 kept across disable", 8'h66, 0, 0);
        pop();

        // R10 address filter
        nine_bit_mode = 1'b1;
        addr_detect_en = 1'b1;
        send(8'h12, 1'b0, 1'b1);
        chk("R10 data char dropped", rx_avail, 0);
        send(8'h9A, 1'b1, 1'b1);
        chk_head("R10 address kept", 8'h9A, 1, 0);
        pop();
        nine_bit_mode = 1'b0;
        send(8'h5A, 1'b0, 1'b1);
        chk_head("R10 8-bit unaffected", 8'h5A, 0, 0);
        pop();
        addr_detect_en = 1'b0;

        // R11 short glitch rejected
        @(negedge clk) rx_serial = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rx_serial = 1'b1;
        repeat (12 * BIT_CLKS) @(negedge clk);
        chk("R11 glitch ignored", rx_avail, 0);

        // Random frames: R2 R3 R10
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d;
            bit nine, adr, b8;
            d    = 8'($urandom);
            nine = 1'($urandom);
            adr  = 1'($urandom);
            b8   = 1'($urandom);
            nine_bit_mode  = nine;
            addr_detect_en = adr;
            send(d, b8, 1'b1);
            if (exp_keep(nine, adr, b8)) begin
                chk_head("R2 R3 random", d, exp_bit8(nine, b8), 0);
                pop();
            end
            chk("R10 random empty", rx_avail, 0);
        end

        summary();
    end
endmodule